// File: doc/BRIEF.md
# Dual-Lane Select-Framed Serial Receiver

This block receives serial frames as the slave end of an SPI link. It has two data inputs that share one serial clock and one active-low select line. Each lane shifts in a 24-bit frame at the same moment. At the end of the frame the block hands both words to the system side together, under one valid strobe.

Frame boundaries come only from the select line. Each falling edge of select arms the receiver and clears its bit count and shift registers. A frame is accepted only when select rises after exactly 24 sampling edges. Any shorter or longer burst is dropped and reported. Because of this, a receiver that comes out of reset in the middle of a transfer loses at most that one frame.

All four serial inputs pass through synchronisers into the system clock domain, which runs much faster than the serial clock. They are oversampled there. Each word carries an even parity check. The block flags a new frame that arrives before the previous one was acknowledged.

Top module: `dual_spi_frame_rx`

## Requirements
- R1: After reset, both output words, both parity flags, the valid strobe, the framing-error strobe and the overrun flag are all 0.
- R2: The interface runs in SPI mode 1 (clock idles low). Data is sampled on each falling clock edge, most significant bit first. Each 24-bit frame appears right-aligned in a 32-bit output word, with bits 31:24 set to zero.
- R3: Both lanes are captured on the same clock edges. One valid strobe, lasting exactly one system-clock cycle, covers both output words.
- R4: A falling edge on select clears the bit count and the shift contents. A frame is accepted when select rises after exactly 24 falling clock edges.
- R5: If select rises after fewer or more than 24 falling edges, the block gives a one-cycle framing-error pulse and no valid strobe. The output words keep their earlier values.
- R6: If reset is released while a frame is in progress, that frame gives a framing-error pulse and is lost. The next complete frame is received correctly.
- R7: Clock edges while select is held high produce no valid and no framing-error pulse. While select stays low, nothing completes, however many clock edges arrive.
- R8: Each lane has a parity-error flag. It is 1 when the XOR of that lane's 24 received bits is 1, meaning even parity over the frame failed. The flag is updated with the word.
- R9: The overrun flag goes to 1 when a frame is accepted while the previous frame has not yet been acknowledged. A high level on the acknowledge input clears both the pending state and the overrun flag.
- R10: The output words and parity flags change only in the cycle in which the valid strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master |
| sel_n_i | input | 1 | Active-low frame select |
| sdi_a_i | input | 1 | Serial data, lane A |
| sdi_b_i | input | 1 | Serial data, lane B |
| ack_i | input | 1 | Acknowledge of the delivered frame pair |
| word_a_o | output | 32 | Last accepted frame, lane A |
| word_b_o | output | 32 | Last accepted frame, lane B |
| perr_a_o | output | 1 | Parity error, lane A |
| perr_b_o | output | 1 | Parity error, lane B |
| valid_o | output | 1 | One-cycle strobe: a new frame pair was accepted |
| frame_err_o | output | 1 | One-cycle strobe: a mis-sized frame was dropped |
| overrun_o | output | 1 | A frame was accepted before the previous one was acknowledged |

## Verification
The case that is hardest to reach from the ports is a receiver joining a transfer that is already under way. That needs the select line already low and clock edges already counted by the master while the block is still held in reset.

The bench drives select low and toggles the serial clock with reset asserted. It releases reset after ten bits and finishes the burst. It then checks two things: the burst ends in a framing error, and the next full frame arrives intact. It also sends bursts of 23 and 25 bits, keeps select low for many bits, and toggles the clock with select high. These show that the count never carries over from one select cycle to the next.

// File: rtl/dual_spi_frame_rx.sv
module dual_spi_frame_rx #(
  parameter int FRAME_BITS  = 24,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sel_n_i,
  input  logic              sdi_a_i,
  input  logic              sdi_b_i,
  input  logic              ack_i,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o,
  output logic              perr_a_o,
  output logic              perr_b_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] sck_sy, sel_sy, da_sy, db_sy;
  logic sck_q, sel_q, armed, pending;
  logic [CW-1:0] cnt;
  logic [FRAME_BITS-1:0] sh_a, sh_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0;
      sel_sy <= '1;
      da_sy  <= '0;
      db_sy  <= '0;
      sck_q  <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck_i};
      sel_sy <= {sel_sy[SYNC_STAGES-2:0], sel_n_i};
      da_sy  <= {da_sy[SYNC_STAGES-2:0], sdi_a_i};
      db_sy  <= {db_sy[SYNC_STAGES-2:0], sdi_b_i};
      sck_q  <= sck_sy[SYNC_STAGES-1];
      sel_q  <= sel_sy[SYNC_STAGES-1];
    end

  wire sck_fall = sck_q & ~sck_sy[SYNC_STAGES-1];
  wire sel_fall = sel_q & ~sel_sy[SYNC_STAGES-1];
  wire sel_rise = ~sel_q & sel_sy[SYNC_STAGES-1];
  wire accept   = sel_rise & armed & (cnt == CNT_FULL);
  wire misframe = sel_rise & armed & (cnt != CNT_FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      sh_a  <= '0;
      sh_b  <= '0;
    end else if (sel_fall) begin
      armed <= 1'b1;
      cnt   <= '0;
      sh_a  <= '0;
      sh_b  <= '0;
    end else if (sel_rise) begin
      armed <= 1'b0;
    end else if (armed && sck_fall) begin
      sh_a <= {sh_a[FRAME_BITS-2:0], da_sy[SYNC_STAGES-1]};
      sh_b <= {sh_b[FRAME_BITS-2:0], db_sy[SYNC_STAGES-1]};
      cnt  <= (cnt == CNT_SAT) ? cnt : cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_a_o    <= '0;
      word_b_o    <= '0;
      perr_a_o    <= 1'b0;
      perr_b_o    <= 1'b0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
      pending     <= 1'b0;
    end else begin
      valid_o     <= accept;
      frame_err_o <= misframe;
      if (accept) begin
        word_a_o <= WORD_W'(sh_a);
        word_b_o <= WORD_W'(sh_b);
        perr_a_o <= ^sh_a;
        perr_b_o <= ^sh_b;
      end
      if (accept) pending <= 1'b1;
      else if (ack_i) pending <= 1'b0;
      if (accept && pending && !ack_i) overrun_o <= 1'b1;
      else if (ack_i) overrun_o <= 1'b0;
    end

  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r5_no_valid_with_error: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && frame_err_o));
  a_r10_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(word_a_o) && $stable(word_b_o) && $stable(perr_a_o) && $stable(perr_b_o)));
  a_r9_overrun_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> valid_o);
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_SAT);
  a_r7_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !sel_rise |=> !valid_o && !frame_err_o);
endmodule

// File: tb/dual_spi_frame_rx_bench.sv
module dual_spi_frame_rx_bench;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, sck = 0, sel_n = 1, da = 0, db = 0, ack = 0;
  logic [31:0] wa, wb;
  logic pa, pb, vld, ferr, ovr;
  int checks = 0, fails = 0, nvalid = 0, nferr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_spi_frame_rx u_dual_spi_frame_rx (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sel_n_i(sel_n), .sdi_a_i(da), .sdi_b_i(db),
    .ack_i(ack), .word_a_o(wa), .word_b_o(wb), .perr_a_o(pa), .perr_b_o(pb),
    .valid_o(vld), .frame_err_o(ferr), .overrun_o(ovr));

  always @(negedge clk) begin
    if (vld) nvalid++;
    if (ferr) nferr++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input int n, input logic [23:0] a, input logic [23:0] b);
    for (int i = 0; i < n; i++) begin
      sck = 1;
      da = (i < 24) ? a[23-i] : 1'b0;
      db = (i < 24) ? b[23-i] : 1'b0;
      wcyc(H);
      sck = 0;
      wcyc(H);
    end
  endtask

  task automatic frame(input int n, input logic [23:0] a, input logic [23:0] b);
    sel_n = 0; wcyc(H);
    bits(n, a, b);
    sel_n = 1; wcyc(12);
  endtask

  task automatic do_ack;
    ack = 1; wcyc(1); ack = 0; wcyc(1);
  endtask

  localparam logic [53:0] VEC [6] = '{
    {6'd24, 24'hA5C3E1, 24'h0F0F0F},
    {6'd24, 24'h800001, 24'h7FFFFE},
    {6'd23, 24'h123456, 24'h654321},
    {6'd25, 24'hFFFFFF, 24'h000000},
    {6'd24, 24'hFFFFFE, 24'h000001},
    {6'd1,  24'h800000, 24'h800000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lasta, lastb;
    int v0, f0;
    wcyc(4);
    chk(wa == 0 && wb == 0, "R1", "words after reset", wa, 0);
    chk({pa, pb, vld, ferr, ovr} == 0, "R1", "flags after reset", {pa, pb, vld, ferr, ovr}, 0);
    rst_n = 1; wcyc(4);
    lasta = 0; lastb = 0;

    foreach (VEC[k]) begin
      int n;
      logic [23:0] a, b;
      n = int'(VEC[k][53:48]); a = VEC[k][47:24]; b = VEC[k][23:0];
      v0 = nvalid; f0 = nferr;
      frame(n, a, b);
      if (n == 24) begin
        chk(nvalid == v0 + 1 && nferr == f0, "R3", "one valid strobe", nvalid - v0, 1);
        chk(wa == {8'h0, a}, "R2", "lane A word", wa, {8'h0, a});
        chk(wb == {8'h0, b}, "R3", "lane B word", wb, {8'h0, b});
        chk(pa == ^a && pb == ^b, "R8", "parity flags", {pa, pb}, {^a, ^b});
        lasta = {8'h0, a}; lastb = {8'h0, b};
      end else begin
        chk(nvalid == v0 && nferr == f0 + 1, "R5", "misframe pulse", nferr - f0, 1);
        chk(wa == lasta && wb == lastb, "R10", "words held", wa, lasta);
      end
      do_ack;
    end

    // R6: reset released mid-frame
    rst_n = 0; sel_n = 0; wcyc(H);
    bits(10, 24'hFFFFFF, 24'hFFFFFF);
    rst_n = 1;
    v0 = nvalid; f0 = nferr;
    bits(14, 24'hFFFFFF, 24'hFFFFFF);
    sel_n = 1; wcyc(12);
    chk(nvalid == v0 && nferr == f0 + 1, "R6", "joined frame dropped", nferr - f0, 1);
    frame(24, 24'h3C3C3C, 24'hC0FFEE);
    chk(nvalid == v0 + 1 && wa == 32'h3C3C3C && wb == 32'hC0FFEE, "R6", "next frame intact", wb, 32'h00C0FFEE);
    do_ack;

    // R7: select high, clocks ignored
    v0 = nvalid; f0 = nferr;
    bits(30, 24'hABCDEF, 24'h123456);
    wcyc(12);
    chk(nvalid == v0 && nferr == f0 && wa == 32'h3C3C3C, "R7", "select high ignored", wa, 32'h3C3C3C);
    // R7: select low, never released
    sel_n = 0; wcyc(H);
    bits(30, 24'h111111, 24'h222222);
    wcyc(12);
    chk(nvalid == v0 && nferr == f0, "R7", "no completion while low", nvalid - v0, 0);
    sel_n = 1; wcyc(12);
    chk(nferr == f0 + 1, "R4", "long select burst is misframe", nferr - f0, 1);

    // R4: a fresh select after a bad burst starts at bit zero
    frame(24, 24'h000003, 24'h800000);
    chk(wa == 32'h3 && wb == 32'h800000 && pa == 0 && pb == 1, "R4", "realigned frame", wa, 32'h3);

    // R9: overrun
    frame(24, 24'h000001, 24'h000002);
    chk(ovr == 1, "R9", "overrun set", ovr, 1);
    do_ack;
    chk(ovr == 0, "R9", "overrun cleared by ack", ovr, 0);
    frame(24, 24'h000004, 24'h000008);
    chk(ovr == 0, "R9", "no overrun after ack", ovr, 0);
    do_ack;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule